// File: doc/BRIEF.md
# SPI Master Controller with Register Bus

This block is a bus-attached SPI master. Software programs it through four 32-bit word locations on a small read/write bus: a packed control/status word, a data port that feeds and drains byte-wide queues, a clock divider and a transfer-length register. The block drives the serial clock, the outgoing data line and three chip-select lines. It samples the incoming data line and raises one interrupt output.

Words written to the data port wait in a 16-entry transmit queue. A shift engine takes them one at a time while the transfer-active flag is set. Each received word enters a 16-entry receive queue, which reads of the data port drain. All four clock-polarity and clock-phase combinations are supported, and the bit order is MSB first. An optional 9-bit word mode sends bits [8:0] of each queued entry.

The shift engine is a three-state machine. In `E_IDLE` SCLK is parked at the idle polarity. It moves to `E_SHIFT` when the transfer flag is set, the transmit queue holds a word and the receive queue has room. In `E_SHIFT` SCLK toggles once per half period until all 16 or 18 edges have been produced, and the next state is `E_PUSH`. `E_PUSH` stores the received word and returns to `E_IDLE`. Clearing the transfer flag in `E_SHIFT` sends the engine straight back to `E_IDLE`.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset the control/status word (word 0) reads 0x00040000, the divider reads 0, all chip-select outputs are high, SCLK is 0 and the interrupt is low.
- R2: Word 2 holds a 16-bit divider and word 3 holds a 16-bit length; both read back as written. The writable control fields read back at their positions in word 0: [1:0] select, 2 phase, 3 polarity, 6 global active-high, 7 transfer active, 9 done-interrupt enable, 10 read-interrupt enable, 12 read-enable flag, 13 nine-bit mode, [23:21] active-high level per line 0..2.
- R3: Each word is shifted MSB first. With phase 0, data is sampled on the leading SCLK edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. The received word reads back from word 1 in bits [8:0], with bit 8 zero in 8-bit mode.
- R4: SCLK rests at the polarity bit whenever no word is shifting. Each half period lasts floor(D/2) system clocks for divider D. D=1 behaves like D=2, and D=0 means 65536 (32768 clocks per half).
- R5: The select field picks one line, and the value 3 selects none. A line's active level is high when bit 6 or its own bit 21+i is set, and low otherwise. Only the selected line is active, and only while bit 7 is set. Every other line sits at the opposite level.
- R6: Status bit 16 reads 1 exactly when bit 7 is set, the transmit queue is empty and no word is shifting.
- R7: The transmit queue holds 16 words. Status bit 18 is 1 while the queue is not full, and a data write to a full queue is dropped.
- R8: Status bit 17 is set when the receive queue is not empty. Bit 19 is set when it holds 12 or more words while bit 7 is set, and bit 20 is set when it is full. Reads of word 1 pop words in arrival order. The engine waits instead of overrunning a full receive queue.
- R9: The interrupt is high when bit 9 is set and status bit 16 is set, or when bit 10 is set and status bit 19 is set. Otherwise it is low.
- R10: Writing 1 to bit 4 empties the transmit queue and writing 1 to bit 5 empties the receive queue. Both bits always read 0.
- R11: Clearing bit 7 in the middle of a word stops the engine, returns SCLK to the polarity level and releases the chip selects.
- R12: With bit 13 set, each queued word is shifted as 9 bits taken from bits [8:0] of the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word index: 0 control/status, 1 data, 2 divider, 3 length |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; pops the receive queue when bus_addr is 1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 3 | Chip-select lines 0..2 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a full receive queue while transmit words are still waiting: the engine must stall, not overwrite. The bench fills the transmit queue past its capacity while the transfer flag is off, then loops MOSI back to MISO and lets the engine run. This fills the receive queue exactly, with one write dropped. The bench then checks the full, threshold and interrupt flags, and checks that the popped words are the first sixteen written, in order. The divider-0 case is reached by measuring one SCLK half period and aborting the word.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_SHIFT = 2'd1,
        E_PUSH  = 2'd2
    } eng_state_t;

    localparam int WORD_W = 9;
    localparam int NUM_CS = 3;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_DIV  = 2'd2;
    localparam logic [1:0] RA_LEN  = 2'd3;

    localparam int B_CPHA   = 2;
    localparam int B_CPOL   = 3;
    localparam int B_CLRTX  = 4;
    localparam int B_CLRRX  = 5;
    localparam int B_CSACT  = 6;
    localparam int B_TA     = 7;
    localparam int B_INTD   = 9;
    localparam int B_INTR   = 10;
    localparam int B_REN    = 12;
    localparam int B_WIDE   = 13;
    localparam int B_DONE   = 16;
    localparam int B_RXD    = 17;
    localparam int B_TXD    = 18;
    localparam int B_RXR    = 19;
    localparam int B_RXF    = 20;
    localparam int B_LPOL   = 21;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH):0]       count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == DEPTH_V);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + {{(AW-1){1'b0}}, 1'b1};
            if (do_pop)  rd_ptr <= rd_ptr + {{(AW-1){1'b0}}, 1'b1};
            count <= count + {{(CW-1){1'b0}}, do_push} - {{(CW-1){1'b0}}, do_pop};
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] half_m1;
    logic [DIV_W-1:0] cnt;

    // Half period = floor(div/2) clocks; 0 -> 2^(DIV_W-1); 1 -> 1.
    always_comb begin
        if (div == '0)
            half_m1 = {1'b0, {(DIV_W-1){1'b1}}};
        else if (div[DIV_W-1:1] == '0)
            half_m1 = '0;
        else
            half_m1 = {1'b0, div[DIV_W-1:1]} - {{(DIV_W-1){1'b0}}, 1'b1};
    end

    assign tick = run && (cnt == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ta,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              wide,
    input  logic              tick,
    input  logic              tx_avail,
    input  logic              rx_room,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    output logic              run,
    output logic              idle
);
    localparam logic [4:0] LAST_NARROW = 5'd15;
    localparam logic [4:0] LAST_WIDE   = 5'd17;

    eng_state_t        st;
    eng_state_t        st_nx;
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [4:0]        edge_cnt;
    logic              cpha_l;
    logic              wide_l;
    logic              sclk_q;
    logic              last_edge;
    logic              leading;

    assign leading   = ~edge_cnt[0];
    assign last_edge = tick && (edge_cnt == (wide_l ? LAST_WIDE : LAST_NARROW));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= st_nx;
    end

    // Next state and strobes
    always_comb begin
        st_nx   = st;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (st)
            E_IDLE: begin
                if (ta && tx_avail && rx_room) begin
                    st_nx  = E_SHIFT;
                    tx_pop = 1'b1;
                end
            end
            E_SHIFT: begin
                if (!ta)            st_nx = E_IDLE;
                else if (last_edge) st_nx = E_PUSH;
            end
            E_PUSH: begin
                rx_push = 1'b1;
                st_nx   = E_IDLE;
            end
            default: st_nx = E_IDLE;
        endcase
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            rx_sr    <= '0;
            edge_cnt <= '0;
            cpha_l   <= 1'b0;
            wide_l   <= 1'b0;
            sclk_q   <= 1'b0;
        end else if (st == E_IDLE) begin
            sclk_q   <= cpol;
            edge_cnt <= '0;
            if (tx_pop) begin
                tx_sr  <= wide ? tx_data : {tx_data[7:0], 1'b0};
                rx_sr  <= '0;
                cpha_l <= cpha;
                wide_l <= wide;
            end
        end else if (st == E_SHIFT) begin
            if (!ta) begin
                sclk_q <= cpol;
            end else if (tick) begin
                sclk_q   <= ~sclk_q;
                edge_cnt <= edge_cnt + 5'd1;
                if (cpha_l ? !leading : leading)
                    rx_sr <= {rx_sr[WORD_W-2:0], miso};
                if (cpha_l ? (leading && edge_cnt != 5'd0) : !leading)
                    tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign rx_data = wide_l ? rx_sr : {1'b0, rx_sr[7:0]};
    assign mosi    = tx_sr[WORD_W-1];
    assign sclk    = sclk_q;
    assign run     = (st == E_SHIFT);
    assign idle    = (st == E_IDLE);

endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
    import spim_pkg::*;
#(
    parameter int TX_DEPTH  = 16,
    parameter int RX_DEPTH  = 16,
    parameter int RX_THRESH = 12,
    parameter int DIV_W     = 16,
    parameter int LEN_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [2:0]  cs_out,
    output logic        irq
);
    localparam int TCW = $clog2(TX_DEPTH) + 1;
    localparam int RCW = $clog2(RX_DEPTH) + 1;
    localparam logic [RCW-1:0] RX_THR_V = RCW'(RX_THRESH);

    logic [1:0]        sel_q;
    logic              cpha_q, cpol_q, csact_q, ta_q;
    logic              intd_en_q, intr_en_q, ren_q, wide_q;
    logic [NUM_CS-1:0] linepol_q;
    logic [DIV_W-1:0]  div_q;
    logic [LEN_W-1:0]  dlen_q;

    logic ctrl_wr, data_wr, data_rd, clr_tx, clr_rx;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [TCW-1:0]    tx_cnt;
    logic [RCW-1:0]    rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_pop, rx_push, tick, eng_run, eng_idle;
    logic st_done, st_rxr;
    logic [NUM_CS-1:0] cs_lvl;
    logic unused_bits;

    assign ctrl_wr = bus_wr && (bus_addr == RA_CTRL);
    assign data_wr = bus_wr && (bus_addr == RA_DATA);
    assign data_rd = bus_rd && (bus_addr == RA_DATA);
    assign clr_tx  = ctrl_wr && bus_wdata[B_CLRTX];
    assign clr_rx  = ctrl_wr && bus_wdata[B_CLRRX];
    assign unused_bits = ^{bus_wdata[31:24], bus_wdata[20:16]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            cpha_q    <= 1'b0;
            cpol_q    <= 1'b0;
            csact_q   <= 1'b0;
            ta_q      <= 1'b0;
            intd_en_q <= 1'b0;
            intr_en_q <= 1'b0;
            ren_q     <= 1'b0;
            wide_q    <= 1'b0;
            linepol_q <= '0;
            div_q     <= '0;
            dlen_q    <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                RA_CTRL: begin
                    sel_q     <= bus_wdata[1:0];
                    cpha_q    <= bus_wdata[B_CPHA];
                    cpol_q    <= bus_wdata[B_CPOL];
                    csact_q   <= bus_wdata[B_CSACT];
                    ta_q      <= bus_wdata[B_TA];
                    intd_en_q <= bus_wdata[B_INTD];
                    intr_en_q <= bus_wdata[B_INTR];
                    ren_q     <= bus_wdata[B_REN];
                    wide_q    <= bus_wdata[B_WIDE];
                    linepol_q <= bus_wdata[B_LPOL +: NUM_CS];
                end
                RA_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
                RA_LEN:  dlen_q <= bus_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    spim_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr_tx),
        .push(data_wr), .din(bus_wdata[WORD_W-1:0]),
        .pop(tx_pop), .dout(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr_rx),
        .push(rx_push), .din(rx_word),
        .pop(data_rd), .dout(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(eng_run), .div(div_q), .tick(tick)
    );

    spim_engine u_eng (
        .clk(clk), .rst_n(rst_n), .ta(ta_q), .cpol(cpol_q), .cpha(cpha_q),
        .wide(wide_q), .tick(tick), .tx_avail(!tx_empty), .rx_room(!rx_full),
        .tx_data(tx_head), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_word), .sclk(sclk), .mosi(mosi), .run(eng_run), .idle(eng_idle)
    );

    // Chip-select drive per line
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_lvl[i] = csact_q | linepol_q[i];
        assign cs_out[i] = (ta_q && (sel_q == 2'(i))) ? cs_lvl[i] : ~cs_lvl[i];
    end

    assign st_done = ta_q && tx_empty && eng_idle;
    assign st_rxr  = ta_q && (rx_cnt >= RX_THR_V);
    assign irq     = (intd_en_q && st_done) || (intr_en_q && st_rxr);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_CTRL: begin
                bus_rdata[1:0]                 = sel_q;
                bus_rdata[B_CPHA]              = cpha_q;
                bus_rdata[B_CPOL]              = cpol_q;
                bus_rdata[B_CSACT]             = csact_q;
                bus_rdata[B_TA]                = ta_q;
                bus_rdata[B_INTD]              = intd_en_q;
                bus_rdata[B_INTR]              = intr_en_q;
                bus_rdata[B_REN]               = ren_q;
                bus_rdata[B_WIDE]              = wide_q;
                bus_rdata[B_DONE]              = st_done;
                bus_rdata[B_RXD]               = !rx_empty;
                bus_rdata[B_TXD]               = !tx_full;
                bus_rdata[B_RXR]               = st_rxr;
                bus_rdata[B_RXF]               = rx_full;
                bus_rdata[B_LPOL +: NUM_CS]    = linepol_q;
            end
            RA_DATA: bus_rdata[WORD_W-1:0] = rx_head;
            RA_DIV:  bus_rdata[DIV_W-1:0]  = div_q;
            RA_LEN:  bus_rdata[LEN_W-1:0]  = dlen_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
    parameter int TCW = 5,
    parameter int RCW = 5,
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [1:0]     bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [2:0]     cs_out,
    input logic [2:0]     cs_lvl,
    input logic           sclk,
    input logic           irq,
    input logic           ta_q,
    input logic           cpol_q,
    input logic           eng_idle,
    input logic           intd_en_q,
    input logic           intr_en_q,
    input logic [TCW-1:0] tx_cnt,
    input logic [RCW-1:0] rx_cnt
);
    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= TCW'(TX_DEPTH)); // R7
    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= RCW'(RX_DEPTH)); // R8
    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~(cs_out ^ cs_lvl)) <= 1); // R5
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_q |-> (cs_out == ~cs_lvl)); // R5
    AST_SCLK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_idle && $past(eng_idle) && $stable(cpol_q)) |-> (sclk == cpol_q)); // R4
    AST_TA_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_q |=> eng_idle); // R11
    AST_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[4]) |=> (tx_cnt == '0)); // R10
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!intd_en_q && !intr_en_q) |-> !irq); // R9
endmodule

bind spi_master_ctrl spim_chk #(
    .TCW(TCW), .RCW(RCW), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cs_out(cs_out), .cs_lvl(cs_lvl), .sclk(sclk),
    .irq(irq), .ta_q(ta_q), .cpol_q(cpol_q), .eng_idle(eng_idle),
    .intd_en_q(intd_en_q), .intr_en_q(intr_en_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_spi_master_ctrl.sv
`timescale 1ns/1ps
module sim_spi_master_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, irq;
    logic [2:0]  cs_out;
    logic        inv_b = 1'b0;
    logic        b_cpol = 1'b0;
    logic        b_cpha = 1'b0;
    logic [8:0]  cap = '0;
    int          capn = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    assign miso = mosi ^ inv_b;

    spi_master_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out), .irq(irq)
    );

    // Slave-side capture on the sampling edge of the active mode
    always @(sclk) begin
        if (cs_out[0] == 1'b0 && sclk == (b_cpol ~^ b_cpha)) begin
            cap  = {cap[7:0], mosi};
            capn = capn + 1;
        end
    end

    // {cpol, cpha, wide, invert, divider[7:0], data[8:0]}
    localparam logic [20:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 9'h0A5},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd4, 9'h03C},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd2, 9'h081},
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd6, 9'h07E},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd4, 9'h1A5},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd2, 9'h0F3},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'd3, 9'h000},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd2, 9'h155}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        int k;
        k = 0;
        rd(2'd0, s);
        while (!s[16] && k < 20000) begin
            rd(2'd0, s);
            k++;
        end
        chk(req, {31'b0, s[16]}, 32'd1);
    endtask

    task automatic measure(input logic [15:0] dv, input int exp);
        int n;
        n = 0;
        b_cpol = 1'b1; b_cpha = 1'b0;
        wr(2'd0, 32'h08);
        wr(2'd2, {16'b0, dv});
        wr(2'd1, 32'h5A);
        wr(2'd0, 32'h88);
        while (sclk == 1'b1 && n < 70000) begin @(negedge clk); n++; end
        n = 0;
        while (sclk == 1'b0 && n < 70000) begin @(negedge clk); n++; end
        chk("R4 half period", n, exp);
        wr(2'd0, 32'h08);                       // abort mid-word
        repeat (3) @(negedge clk);
        chk("R11 sclk back to idle", {31'b0, sclk}, 32'd1);
        chk("R11 chip selects released", {29'b0, cs_out}, 32'd7);
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl after reset", d, 32'h00040000);
        rd(2'd2, d); chk("R1 divider after reset", d, 32'h0);
        chk("R1 cs after reset", {29'b0, cs_out}, 32'd7);
        chk("R1 sclk/irq after reset", {30'b0, sclk, irq}, 32'd0);

        // R2 readback
        wr(2'd2, 32'h1234); rd(2'd2, d); chk("R2 divider", d, 32'h1234);
        wr(2'd3, 32'hBEEF); rd(2'd3, d); chk("R2 length", d, 32'hBEEF);
        wr(2'd0, 32'h00E0364A); rd(2'd0, d); chk("R2 control fields", d, 32'h00E4364A);
        wr(2'd0, 32'h0);

        // R3 / R12: table of modes, loopback
        for (int i = 0; i < 8; i++) begin
            logic [20:0] v;
            logic [31:0] mode;
            logic [8:0]  mask, exp_rx;
            int nb;
            v = VEC[i];
            b_cpol = v[20]; b_cpha = v[19]; inv_b = v[17];
            nb   = v[18] ? 9 : 8;
            mask = v[18] ? 9'h1FF : 9'h0FF;
            exp_rx = (v[17] ? ~v[8:0] : v[8:0]) & mask;
            mode = (32'(v[18]) << 13) | (32'(v[20]) << 3) | (32'(v[19]) << 2);
            wr(2'd0, mode);
            wr(2'd2, {24'b0, v[16:9]});
            cap = '0; capn = 0;
            wr(2'd1, {23'b0, v[8:0]});
            wr(2'd0, mode | 32'h80);
            wait_done("R3 word completes");
            wr(2'd0, mode);
            rd(2'd1, d);
            chk(v[18] ? "R12 nine-bit received word" : "R3 received word", d, {23'b0, exp_rx});
            chk(v[18] ? "R12 nine-bit MSB-first stream" : "R3 MSB-first stream",
                {23'b0, cap & mask}, {23'b0, v[8:0] & mask});
            chk("R3 sample edge count", capn, nb);
        end
        inv_b = 1'b0;

        // R4 / R11: divider timing and abort
        measure(16'd6, 3);
        measure(16'd7, 3);
        measure(16'd1, 1);
        measure(16'd0, 32768);
        b_cpol = 1'b0;
        wr(2'd0, 32'h20); wr(2'd0, 32'h10); wr(2'd0, 32'h0);

        // R5 / R6 / R9: chip-select levels, done flag, interrupt gating
        rd(2'd0, d); chk("R6 done needs transfer flag", {31'b0, d[16]}, 32'd0);
        wr(2'd0, 32'h81);
        chk("R5 line 1 active low", {29'b0, cs_out}, 32'd5);
        rd(2'd0, d); chk("R6 done with empty queue", {31'b0, d[16]}, 32'd1);
        chk("R9 irq masked", {31'b0, irq}, 32'd0);
        wr(2'd0, 32'h281);
        chk("R9 done interrupt", {31'b0, irq}, 32'd1);
        wr(2'd0, 32'h00200081);
        chk("R5 per-line level", {29'b0, cs_out}, 32'd4);
        wr(2'd0, 32'hC2);
        chk("R5 global active high", {29'b0, cs_out}, 32'd4);
        wr(2'd0, 32'hC3);
        chk("R5 select none", {29'b0, cs_out}, 32'd0);
        wr(2'd0, 32'h01);
        chk("R5 no transfer flag", {29'b0, cs_out}, 32'd7);

        // R10 transmit clear
        wr(2'd1, 32'h11); wr(2'd1, 32'h22); wr(2'd1, 32'h33);
        wr(2'd0, 32'h10);
        wr(2'd0, 32'h83);
        rd(2'd0, d);
        chk("R10 tx flushed (done, no rx, clear bits read 0)",
            {27'b0, d[17:16], d[5:4], 1'b0}, {27'b0, 2'b01, 2'b00, 1'b0});
        wr(2'd0, 32'h0);

        // R7 / R8 / R9: overfill, stall at full receive queue
        wr(2'd2, 32'd2);
        for (int i = 0; i < 17; i++) wr(2'd1, 32'(i));
        rd(2'd0, d); chk("R7 tx full flag", {31'b0, d[18]}, 32'd0);
        wr(2'd0, 32'h480);
        wait_done("R8 run until rx full");
        rd(2'd0, d); chk("R8 rxf/rxr/txd/rxd/done", {27'b0, d[20:16]}, 32'h1F);
        chk("R9 read-threshold interrupt", {31'b0, irq}, 32'd1);
        for (int i = 0; i < 16; i++) begin
            rd(2'd1, d);
            chk("R8 pop order", d, 32'(i));
            if (i == 4) chk("R9 irq drops below threshold", {31'b0, irq}, 32'd0);
        end
        rd(2'd0, d); chk("R7 extra write dropped (rx empty)", {31'b0, d[17]}, 32'd0);

        // R10 receive clear
        wr(2'd1, 32'hA1); wr(2'd1, 32'hB2);
        wr(2'd0, 32'h80);
        wait_done("R10 two words done");
        rd(2'd0, d); chk("R10 rx holds data", {31'b0, d[17]}, 32'd1);
        wr(2'd0, 32'hA0);
        rd(2'd0, d); chk("R10 rx flushed", {30'b0, d[17], d[5]}, 32'd0);
        wr(2'd0, 32'h0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule